// File: doc/BRIEF.md
# Multithreaded Stream Issue Scheduler

This block chooses, in every cycle, which hardware thread context (a "stream") may issue its next instruction word. Every stream has its own program counter. At most one word goes out per cycle. A stream that has started a long-latency memory operation does not stall straight away. The word that launched the operation carries a lookahead count: the number of further words from the same stream that may issue before the result is needed. The stream stays eligible until that count is used up.

Memory completions arrive on a separate input, tagged with a stream number, and make the stream eligible again. Eligible streams are served round-robin. The search starts at the stream after the one that last issued. A stream can be switched off with its enable bit; its state is kept while it is off. When no stream is eligible, the cycle is a bubble and an idle flag is raised.

The attributes of the word that issues in a cycle (whether it starts a memory operation, and its lookahead count) are presented on the same cycle as the issue. The outside fetch logic supplies them.

Top module: `stream_issue_sched`

## Requirements
- R1: After reset no stream is outstanding, every program counter is 0, and the round-robin pointer sits on the last stream, so stream 0 is searched first.
- R2: When `issue_valid_o` is 1, `issue_sid_o` names a stream that is enabled and ready. A stream is ready when it is enabled and either has no operation outstanding or has a lookahead count that is not zero.
- R3: The stream that issues is the first ready one found by searching upward, with wrap-around, from the stream after the last one that issued.
- R4: `issue_pc_o` shows the issuing stream's program counter, and that counter goes up by 1 (modulo 2^PC_W) on every issue from that stream.
- R5: An issued word with `word_mem_i`=1 from a stream that has nothing outstanding marks the stream outstanding and loads its count from `word_la_i`. If that count is 0, the stream is not ready from the next cycle on.
- R6: Each issue from an outstanding stream lowers its count by 1. While the stream is outstanding, `word_mem_i` has no effect.
- R7: `cpl_valid_i`=1 with `cpl_sid_i`=s clears stream s's outstanding state at the clock edge. If the stream also issues in that same cycle, the issue is treated as coming from a stream with nothing outstanding.
- R8: When no stream is ready, `issue_valid_o` is 0 and `idle_o` is 1. Otherwise `idle_o` is 0.
- R9: A stream whose enable bit is 0 is never selected. Its program counter, outstanding state and count are kept, and completions still reach it.
- R10: A completion for a stream that has nothing outstanding changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stream_en_i | input | N_STREAMS | Per-stream enable |
| word_mem_i | input | 1 | Issued word starts a memory operation |
| word_la_i | input | LA_W | Lookahead count of the issued word |
| cpl_valid_i | input | 1 | Memory completion valid |
| cpl_sid_i | input | SID_W | Stream the completion belongs to |
| issue_valid_o | output | 1 | A word issues this cycle |
| issue_sid_o | output | SID_W | Issuing stream |
| issue_pc_o | output | PC_W | Program counter of the issuing stream |
| idle_o | output | 1 | No stream ready (bubble) |

## Verification
The issue outputs are combinational from the registered stream state and the current enables, so they are due in the same cycle the enables are applied. The bench samples them 1 ns after driving its inputs at the falling edge.

The effects of the word attributes and of a completion land at the next rising edge. They therefore show up only in the selection of the following cycle. The bench's model advances its own state once per cycle, right after its checks, so every expectation refers to exactly the state the registers hold at that sample point.

// File: rtl/sis_pkg.sv
package sis_pkg;
    localparam int LA_W = 4;
    localparam int PC_W = 12;

    typedef struct packed {
        logic            busy;
        logic [LA_W-1:0] la;
        logic [PC_W-1:0] pc;
    } ctx_t;
endpackage

// File: rtl/sis_stream_ctx.sv
module sis_stream_ctx
    import sis_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic            issue_i,
    input  logic            cpl_i,
    input  logic            word_mem_i,
    input  logic [LA_W-1:0] word_la_i,
    output logic            ready_o,
    output logic [PC_W-1:0] pc_o
);
    ctx_t st_d, st_q;
    logic busy_eff;

    always_comb begin
        st_d     = st_q;
        busy_eff = st_q.busy & ~cpl_i;
        if (cpl_i) st_d.busy = 1'b0;
        if (issue_i) begin
            st_d.pc = st_q.pc + 1'b1;
            if (busy_eff) begin
                st_d.la = st_q.la - 1'b1;
            end else if (word_mem_i) begin
                st_d.busy = 1'b1;
                st_d.la   = word_la_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ready_o = en_i & (~st_q.busy | (st_q.la != '0));
    assign pc_o    = st_q.pc;

    AST_LA_DECR: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i && st_q.busy && !cpl_i |=> st_q.la == LA_W'($past(st_q.la) - 1'b1)); // R6
    AST_CPL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_i && !issue_i |=> !st_q.busy); // R7
    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i |=> st_q.pc == PC_W'($past(st_q.pc) + 1'b1)); // R4
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_i && !cpl_i |=> $stable(st_q)); // R9
endmodule

// File: rtl/sis_rr_pick.sv
module sis_rr_pick #(
    parameter int N_STREAMS = 8,
    localparam int SID_W = $clog2(N_STREAMS)
) (
    input  logic [N_STREAMS-1:0] req_i,
    input  logic [SID_W-1:0]     last_i,
    output logic                 gnt_valid_o,
    output logic [SID_W-1:0]     gnt_idx_o
);
    always_comb begin
        gnt_valid_o = 1'b0;
        gnt_idx_o   = '0;
        for (int k = 1; k <= N_STREAMS; k++) begin
            int c;
            c = (int'(last_i) + k) % N_STREAMS;
            if (!gnt_valid_o && req_i[c]) begin
                gnt_valid_o = 1'b1;
                gnt_idx_o   = SID_W'(c);
            end
        end
    end
endmodule

// File: rtl/stream_issue_sched.sv
module stream_issue_sched
    import sis_pkg::*;
#(
    parameter int N_STREAMS = 8,
    localparam int SID_W = $clog2(N_STREAMS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_STREAMS-1:0] stream_en_i,
    input  logic                 word_mem_i,
    input  logic [LA_W-1:0]      word_la_i,
    input  logic                 cpl_valid_i,
    input  logic [SID_W-1:0]     cpl_sid_i,
    output logic                 issue_valid_o,
    output logic [SID_W-1:0]     issue_sid_o,
    output logic [PC_W-1:0]      issue_pc_o,
    output logic                 idle_o
);
    typedef struct packed {
        logic [SID_W-1:0] last;
    } top_t;

    top_t st_d, st_q;
    logic [N_STREAMS-1:0] ready_w;
    logic [PC_W-1:0]      pc_w [N_STREAMS];
    logic                 pick_valid;
    logic [SID_W-1:0]     pick_idx;

    generate
        for (genvar s = 0; s < N_STREAMS; s++) begin : g_ctx
            sis_stream_ctx u_ctx (
                .clk       (clk),
                .rst_n     (rst_n),
                .en_i      (stream_en_i[s]),
                .issue_i   (pick_valid && (pick_idx == SID_W'(s))),
                .cpl_i     (cpl_valid_i && (cpl_sid_i == SID_W'(s))),
                .word_mem_i(word_mem_i),
                .word_la_i (word_la_i),
                .ready_o   (ready_w[s]),
                .pc_o      (pc_w[s])
            );
        end
    endgenerate

    sis_rr_pick #(.N_STREAMS(N_STREAMS)) u_pick (
        .req_i      (ready_w),
        .last_i     (st_q.last),
        .gnt_valid_o(pick_valid),
        .gnt_idx_o  (pick_idx)
    );

    always_comb begin
        st_d = st_q;
        if (pick_valid) st_d.last = pick_idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.last <= SID_W'(N_STREAMS - 1);
        else        st_q <= st_d;
    end

    assign issue_valid_o = pick_valid;
    assign issue_sid_o   = pick_idx;
    assign issue_pc_o    = pc_w[pick_idx];
    assign idle_o        = ~pick_valid;

    AST_PICK_READY: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid_o |-> ready_w[issue_sid_o]); // R2
    AST_PICK_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid_o |-> stream_en_i[issue_sid_o]); // R9
    AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        idle_o |-> ready_w == '0); // R8
endmodule

// File: tb/stream_issue_sched_tb_top.sv
module stream_issue_sched_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] stream_en = '0;
    logic       word_mem = 1'b0;
    logic [3:0] word_la = '0;
    logic       cpl_valid = 1'b0;
    logic [2:0] cpl_sid = '0;
    logic       issue_valid, idle;
    logic [2:0] issue_sid;
    logic [11:0] issue_pc;

    int n_checks = 0;
    int n_fail = 0;

    bit m_busy [N];
    int m_la [N];
    int m_pc [N];
    int m_last;

    always #(CLK_PERIOD/2) clk = ~clk;

    stream_issue_sched #(.N_STREAMS(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .stream_en_i(stream_en),
        .word_mem_i(word_mem), .word_la_i(word_la),
        .cpl_valid_i(cpl_valid), .cpl_sid_i(cpl_sid),
        .issue_valid_o(issue_valid), .issue_sid_o(issue_sid),
        .issue_pc_o(issue_pc), .idle_o(idle)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic bit m_ready(input int s, input logic [7:0] en);
        return en[s] && (!m_busy[s] || m_la[s] != 0);
    endfunction

    function automatic int m_pick(input logic [7:0] en);
        for (int k = 1; k <= N; k++) begin
            int c = (m_last + k) % N;
            if (m_ready(c, en)) return c;
        end
        return -1;
    endfunction

    task automatic step(input logic [7:0] en, input logic m, input logic [3:0] l,
                        input logic cv, input logic [2:0] cs, input string tag);
        int p;
        @(negedge clk);
        stream_en = en; word_mem = m; word_la = l; cpl_valid = cv; cpl_sid = cs;
        #1;
        p = m_pick(en);
        check(tag, "issue_valid", int'(issue_valid), int'(p >= 0));
        check("R8", "idle", int'(idle), int'(p < 0));
        if (p >= 0) begin
            check(tag, "issue_sid", int'(issue_sid), p);
            check("R4", "issue_pc", int'(issue_pc), m_pc[p]);
        end
        for (int s = 0; s < N; s++) begin
            bit be = m_busy[s] && !(cv && int'(cs) == s);
            if (cv && int'(cs) == s) m_busy[s] = 1'b0;
            if (s == p) begin
                m_pc[s] = (m_pc[s] + 1) % 4096;
                if (be) m_la[s] = (m_la[s] - 1) & 15;
                else if (m) begin m_busy[s] = 1'b1; m_la[s] = int'(l); end
            end
        end
        if (p >= 0) m_last = p;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(714);
        for (int s = 0; s < N; s++) begin m_busy[s] = 0; m_la[s] = 0; m_pc[s] = 0; end
        m_last = N - 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", "issue_valid_reset", int'(issue_valid), 0);
        check("R1", "idle_reset", int'(idle), 1);
        step(8'hFF, 0, 0, 0, 0, "R1");
        step(8'hFF, 0, 0, 0, 0, "R3");
        step(8'h81, 0, 0, 0, 0, "R3");
        step(8'h81, 0, 0, 0, 0, "R3");
        // R5 / R6: lookahead run-out on stream 0 alone
        step(8'h01, 1, 4'd2, 0, 0, "R5");
        step(8'h01, 0, 0, 0, 0, "R6");
        step(8'h01, 1, 4'd9, 0, 0, "R6");
        step(8'h01, 0, 0, 0, 0, "R5");
        // R10: completion to an idle stream changes nothing
        step(8'h01, 0, 0, 1, 3'd3, "R10");
        step(8'h08, 0, 0, 0, 0, "R10");
        // R7: completion, ready next cycle
        step(8'h01, 0, 0, 1, 3'd0, "R7");
        step(8'h01, 1, 4'd0, 0, 0, "R7");
        step(8'h01, 0, 0, 1, 3'd0, "R7");
        step(8'h01, 0, 0, 0, 0, "R7");
        // R9: disabled streams skipped, then state kept
        step(8'h00, 0, 0, 0, 0, "R9");
        step(8'h24, 0, 0, 0, 0, "R9");
        step(8'h24, 0, 0, 0, 0, "R9");
        step(8'hFF, 0, 0, 0, 0, "R9");
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] en = 8'($urandom) | 8'($urandom);
            logic m = ($urandom % 3) == 0;
            logic [3:0] l = 4'($urandom % 4);
            logic cv = ($urandom % 4) == 0;
            logic [2:0] cs = 3'($urandom);
            step(en, m, l, cv, cs, "R2");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule